// File: doc/BRIEF.md
# Processor-Controlled I/O Port Register Bank

This block is one 8-bit general-purpose I/O port. A processor drives and observes it through a small synchronous register bus, which carries an address, a write strobe, write data and combinational read data. The processor can read the live pin levels and program an output data value and a per-pin direction. A neighbouring programmable-logic array supplies an extra output-enable term per pin, and a pin drives whenever either source asks it to. An open-drain bit per pin turns a pin into a pull-low-only driver.

The port also carries two small macrocell banks shared with the logic array. The output macrocell flip-flops can be loaded by the processor, and a per-bit blocking mask keeps chosen bits from changing on such a load. Their state is also brought out to the array. The input macrocells capture the pin levels on a latch strobe from the array and hold them for the processor to read. A read-only status register reports which pins are actually driving.

Top module: `port_bank`

## Requirements
- R1: A read of address 0 returns `pinIn` in the same cycle, with no register in the read path.
- R2: Address 1 holds the output data register, and a write to it reads back unchanged from the next cycle on.
- R3: Address 2 holds the direction register. For a pin whose open-drain bit is 0, `pinOe` is the OR of its direction bit and its `plOe` bit, and `pinOut` equals its output data bit.
- R4: A write to address 3 loads the output macrocell flip-flops only at bit positions whose mask bit is 0. Masked bits keep their old value: new = (old AND mask) OR (data AND NOT mask).
- R5: Address 4 holds the blocking mask, which is writable and readable. After reset every register bit, including every mask bit, is 0.
- R6: A read of address 3 returns the present macrocell flip-flop state, and this state is also driven on `mcellQ`.
- R7: The input macrocells at address 5 take `pinIn` at a clock edge where `imcLatch` is 1, and otherwise hold their value whatever the pins do.
- R8: A read of address 6 returns `pinOe`, where 1 means the pin drives and 0 means it is high impedance. Writes to addresses 0, 5 and 6 change nothing.
- R9: Address 7 holds the open-drain register. For a pin with its open-drain bit at 1, `pinOut` is 0 and `pinOe` is 1 only when the pin is enabled (direction OR `plOe`) and its output data bit is 0.
- R10: Reads of addresses 8 to 15 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from `addr` |
| pinIn | input | 8 | Pin input levels |
| plOe | input | 8 | Output-enable terms from the logic array |
| imcLatch | input | 1 | Input-macrocell capture strobe |
| pinOut | output | 8 | Pin output levels |
| pinOe | output | 8 | Per-pin driver enables |
| mcellQ | output | 8 | Output macrocell flip-flop state |

## Verification
The pin read is swept over all 256 input values, which separates a direct path from a registered or bit-swapped one. The masked macrocell load is tried with mask values that are all-clear, all-set, alternating and split by nibble, each against several data words. This exposes an inverted mask, an ignored mask or a mask applied to the wrong operand. The output-enable logic is swept over crossed patterns of the direction bits and the logic-array terms, first with push-pull pins and then with a half-open-drain setting. This tells an OR from an AND or a single-source enable, and shows whether open drain honours the data bit. Writes to read-only and unmapped addresses are followed by a full register read-back, which proves that nothing changed.

// File: rtl/port_bank_pkg.sv
package port_bank_pkg;

  // Register addresses (low part of the address bus)
  localparam int ADR_PIN   = 0;
  localparam int ADR_DOUT  = 1;
  localparam int ADR_DIR   = 2;
  localparam int ADR_MCELL = 3;
  localparam int ADR_MASK  = 4;
  localparam int ADR_IMC   = 5;
  localparam int ADR_OESTS = 6;
  localparam int ADR_ODRN  = 7;
  localparam int NUM_MAPPED = 8;

  typedef enum logic [3:0] {
    RD_PIN,
    RD_DOUT,
    RD_DIR,
    RD_MCELL,
    RD_MASK,
    RD_IMC,
    RD_OESTS,
    RD_ODRN,
    RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   ldDout;
    logic   ldDir;
    logic   ldMcell;
    logic   ldMask;
    logic   ldOdrn;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/port_bank_ctrl.sv
module port_bank_ctrl
  import port_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output ctrlStrobes_t      strobes
);

  localparam logic [ADDR_W-1:0] LAST_MAPPED = ADDR_W'(NUM_MAPPED - 1);

  logic mapped;
  assign mapped = (addr <= LAST_MAPPED);

  always_comb begin
    strobes         = '0;
    strobes.rdSel   = RD_ZERO;
    if (mapped) begin
      if (addr == ADDR_W'(ADR_PIN))   strobes.rdSel = RD_PIN;
      if (addr == ADDR_W'(ADR_DOUT))  strobes.rdSel = RD_DOUT;
      if (addr == ADDR_W'(ADR_DIR))   strobes.rdSel = RD_DIR;
      if (addr == ADDR_W'(ADR_MCELL)) strobes.rdSel = RD_MCELL;
      if (addr == ADDR_W'(ADR_MASK))  strobes.rdSel = RD_MASK;
      if (addr == ADDR_W'(ADR_IMC))   strobes.rdSel = RD_IMC;
      if (addr == ADDR_W'(ADR_OESTS)) strobes.rdSel = RD_OESTS;
      if (addr == ADDR_W'(ADR_ODRN))  strobes.rdSel = RD_ODRN;
    end
    // Only writable registers get a load strobe; read-only ones never do.
    strobes.ldDout  = wrEn && (addr == ADDR_W'(ADR_DOUT));
    strobes.ldDir   = wrEn && (addr == ADDR_W'(ADR_DIR));
    strobes.ldMcell = wrEn && (addr == ADDR_W'(ADR_MCELL));
    strobes.ldMask  = wrEn && (addr == ADDR_W'(ADR_MASK));
    strobes.ldOdrn  = wrEn && (addr == ADDR_W'(ADR_ODRN));
  end

endmodule

// File: rtl/port_bank_dp.sv
module port_bank_dp
  import port_bank_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] plOe,
  input  logic             imcLatch,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] mcellQ
);

  logic [WIDTH-1:0] doutQ, dirQ, mcellReg, maskQ, odrnQ, imcQ;
  logic [WIDTH-1:0] enRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doutQ <= '0;
      dirQ  <= '0;
      maskQ <= '0;
      odrnQ <= '0;
      imcQ  <= '0;
    end else begin
      if (strobes.ldDout) doutQ <= wrData;
      if (strobes.ldDir)  dirQ  <= wrData;
      if (strobes.ldMask) maskQ <= wrData;
      if (strobes.ldOdrn) odrnQ <= wrData;
      if (imcLatch)       imcQ  <= pinIn;
    end
  end

  // Per-bit macrocell flip-flops with blocking mask
  for (genvar i = 0; i < WIDTH; i++) begin : g_mcell
    always_ff @(posedge clk) begin
      if (!rstN)                            mcellReg[i] <= 1'b0;
      else if (strobes.ldMcell && !maskQ[i]) mcellReg[i] <= wrData[i];
    end
  end

  // Per-pin driver logic
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign enRaw[i]  = dirQ[i] | plOe[i];
    assign pinOut[i] = odrnQ[i] ? 1'b0 : doutQ[i];
    assign pinOe[i]  = odrnQ[i] ? (enRaw[i] & ~doutQ[i]) : enRaw[i];
  end

  assign mcellQ = mcellReg;

  always_comb begin
    case (strobes.rdSel)
      RD_PIN:   rdData = pinIn;
      RD_DOUT:  rdData = doutQ;
      RD_DIR:   rdData = dirQ;
      RD_MCELL: rdData = mcellReg;
      RD_MASK:  rdData = maskQ;
      RD_IMC:   rdData = imcQ;
      RD_OESTS: rdData = pinOe;
      RD_ODRN:  rdData = odrnQ;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/port_bank.sv
module port_bank
  import port_bank_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  pinIn,
  input  logic [WIDTH-1:0]  plOe,
  input  logic              imcLatch,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  output logic [WIDTH-1:0]  mcellQ
);

  ctrlStrobes_t strobes;

  port_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr    (addr),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  port_bank_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .plOe     (plOe),
    .imcLatch (imcLatch),
    .rdData   (rdData),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .mcellQ   (mcellQ)
  );

endmodule

// File: rtl/port_bank_chk.sv
module port_bank_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [WIDTH-1:0]  wrData,
  input logic [WIDTH-1:0]  rdData,
  input logic [WIDTH-1:0]  pinIn,
  input logic [WIDTH-1:0]  pinOe,
  input logic [WIDTH-1:0]  mcellQ
);

  // Shadow of the mask register, rebuilt from bus writes
  logic [WIDTH-1:0] maskShadow;
  always_ff @(posedge clk) begin
    if (!rstN)                                  maskShadow <= '0;
    else if (wrEn && addr == ADDR_W'(4))        maskShadow <= wrData;
  end

  // R1
  pin_read_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(0)) |-> (rdData == pinIn));

  // R2
  dout_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && $past(addr) == ADDR_W'(1) && addr == ADDR_W'(1)) |-> (rdData == $past(wrData)));

  // R4
  masked_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(3)) |=>
      (mcellQ == (($past(mcellQ) & $past(maskShadow)) | ($past(wrData) & ~$past(maskShadow)))));

  // R6
  mcell_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(3)) |-> (rdData == mcellQ));

  // R8
  oe_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(6)) |-> (rdData == pinOe));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr >= ADDR_W'(8)) |-> (rdData == '0));

endmodule

bind port_bank port_bank_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdData (rdData),
  .pinIn  (pinIn),
  .pinOe  (pinOe),
  .mcellQ (mcellQ)
);

// File: tb/sim_port_bank.sv
`timescale 1ns/100ps
module sim_port_bank;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] pinIn = '0;
  logic [7:0] plOe = '0;
  logic       imcLatch = 1'b0;
  logic [7:0] pinOut, pinOe, mcellQ;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model
  logic [7:0] doutM = '0, dirM = '0, mcellM = '0, maskM = '0, odM = '0, imcM = '0;

  always #2.5 clk = ~clk;

  port_bank u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .plOe(plOe), .imcLatch(imcLatch),
    .pinOut(pinOut), .pinOe(pinOe), .mcellQ(mcellQ)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  function automatic logic [7:0] oeExp();
    logic [7:0] en;
    en = dirM | plOe;
    return (en & ~odM) | (en & odM & ~doutM);
  endfunction

  task automatic readAll(input string tag);
    rdChk(tag, 4'd1, doutM);
    rdChk(tag, 4'd2, dirM);
    rdChk(tag, 4'd3, mcellM);
    rdChk(tag, 4'd4, maskM);
    rdChk(tag, 4'd5, imcM);
    rdChk(tag, 4'd6, oeExp());
    rdChk(tag, 4'd7, odM);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] masks [5];
    logic [7:0] pats  [4];
    masks = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h0F};
    pats  = '{8'h00, 8'hFF, 8'h5A, 8'hC3};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R5: reset state of every register and pin output
    readAll("R5 reset");
    chk("R5 reset pinOe", pinOe, 8'h00);
    chk("R5 reset pinOut", pinOut, 8'h00);

    // R1: sweep all pin values
    for (int v = 0; v < 256; v++) begin
      pinIn = 8'(v);
      rdChk("R1 pin read", 4'd0, 8'(v));
    end

    // R2: data-out readback
    for (int v = 0; v < 256; v += 17) begin
      wr(4'd1, 8'(v)); doutM = 8'(v);
      rdChk("R2 dout readback", 4'd1, doutM);
    end

    // R4 R5 R6: masked macrocell loads
    foreach (masks[m]) begin
      wr(4'd4, masks[m]); maskM = masks[m];
      rdChk("R5 mask readback", 4'd4, maskM);
      for (int v = 0; v < 256; v += 37) begin
        wr(4'd3, 8'(v));
        mcellM = (mcellM & maskM) | (8'(v) & ~maskM);
        rdChk("R4 masked load", 4'd3, mcellM);
        chk("R6 mcellQ port", mcellQ, mcellM);
      end
    end

    // R3: push-pull enable = dir OR plOe
    foreach (pats[p]) begin
      wr(4'd1, pats[p]); doutM = pats[p];
      foreach (pats[q]) begin
        wr(4'd2, pats[q] ^ 8'h0F); dirM = pats[q] ^ 8'h0F;
        foreach (pats[r]) begin
          @(negedge clk); plOe = pats[r]; #1;
          chk("R3 pinOe", pinOe, dirM | plOe);
          chk("R3 pinOut", pinOut, doutM);
        end
      end
    end

    // R9: open drain
    wr(4'd7, 8'hF0); odM = 8'hF0;
    foreach (pats[p]) begin
      wr(4'd1, pats[p]); doutM = pats[p];
      foreach (pats[r]) begin
        @(negedge clk); plOe = pats[r]; #1;
        chk("R9 od pinOut", pinOut, doutM & ~odM);
        chk("R9 od pinOe", pinOe, oeExp());
        rdChk("R8 oe status", 4'd6, oeExp());
      end
    end

    // R7: input macrocell latch and hold
    @(negedge clk); pinIn = 8'h96; imcLatch = 1'b1;
    @(negedge clk); imcLatch = 1'b0; imcM = 8'h96;
    rdChk("R7 imc capture", 4'd5, imcM);
    @(negedge clk); pinIn = 8'h21;
    repeat (3) @(negedge clk);
    rdChk("R7 imc hold", 4'd5, imcM);
    @(negedge clk); imcLatch = 1'b1;
    @(negedge clk); imcLatch = 1'b0; imcM = 8'h21;
    rdChk("R7 imc recapture", 4'd5, imcM);

    // R8: writes to read-only addresses ignored
    wr(4'd0, 8'hEE);
    wr(4'd5, 8'hEE);
    wr(4'd6, 8'hEE);
    readAll("R8 ro write ignored");
    rdChk("R8 pin still live", 4'd0, pinIn);

    // R10: unmapped reads zero, writes ignored
    for (int a = 8; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      rdChk("R10 unmapped read", 4'(a), 8'h00);
    end
    readAll("R10 unmapped write ignored");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule